// File: doc/BRIEF.md
# Two-Level Context Address Translator

This block sits between a processor bus and the memory system and turns 32-bit virtual byte addresses into physical word addresses. Each access carries an address-space identifier (ASI). One ASI value opens a small system space holding a context register and a system enable register. Two more values give direct read and write access to the two translation tables. Four values perform translated user/supervisor instruction and data accesses. The first table, the segment map, is private to each context and yields a page-group number. The second table, the page map, is shared and is indexed by that group number together with the page number inside the segment.

A translated access returns a physical word address made of the entry's frame number and the word offset within the 4 KiB page. It also raises one of two downstream space selects, chosen by the entry's two-bit space type. The block marks entries as accessed when a translation succeeds. It flags accesses to invalid entries, user accesses to supervisor-only pages and writes to read-only pages as faults. While the system enable register says the machine is still booting, supervisor instruction fetches bypass translation and read the boot ROM directly. Requests are combinational: the response appears in the cycle the request is presented, and table and register updates take effect at the following clock edge.

Top module: `ctx_mmu_xlate`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears the context register, the system enable register and both tables to zero, so right after reset a supervisor instruction fetch (ASI 9) is served from the boot ROM.
- R2: With ASI 2, byte-address bits 31:28 pick a register: value 3 is the context register (its low CTX_BITS bits in rd_data bits 31:24, written from wdata bits 31:24 when be[3] is set, upper bits dropped); value 4 is the 8-bit system enable register in bits 31:24; any other value reads as zero.
- R3: With ASI 3 the segment map entry of the current context indexed by address bits from 18 upward is read or written; be=1100 places the entry in data bits 23:16, be=1000 in bits 31:24, any other byte-enable pattern reads zero and writes nothing; a written entry keeps only its low GRP_BITS bits.
- R4: With ASI 4 the page map entry at index {group, address bits 17:12} is read in full, or written byte by byte under be, with bits 23:16 of the stored entry forced to zero.
- R5: For ASI 8 to 11 through a usable entry, pa_word is {entry bits 15:0, address bits 11:2}; entry type (bits 27:26) 0 raises sp0_sel and 1 raises sp1_sel; types 2 and 3 raise no select and read zero; a translated read returns ext_rdata and a translated write returns zero.
- R6: A translated access that raises no fault sets bit 25 (accessed) of the entry it used.
- R7: A translated access through an entry with bit 31 clear reports fault_kind 1, returns zero and raises no select.
- R8: A user access (ASI 8 or 10) through an entry with bit 29 (supervisor-only) set reports fault_kind 2.
- R9: A translated write through a valid entry with bit 30 (writable) clear reports fault_kind 3 and raises no select.
- R10: While system enable bit 7 is clear, an ASI 9 read raises rom_sel with rom_addr equal to address bits 18:2 and returns rom_rdata; once bit 7 is set, ASI 9 is translated.
- R11: Segment lookups always use the current context, so the same virtual address maps through different groups in different contexts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_asi | input | 8 | Address-space identifier |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Virtual byte address |
| req_be | input | 4 | Byte enables, bit 3 is bits 31:24 |
| req_wdata | input | 32 | Write data |
| ext_rdata | input | 32 | Read data from the selected downstream space |
| rom_rdata | input | 32 | Read data from the boot ROM |
| rd_data | output | 32 | Read response |
| sp0_sel | output | 1 | Translated access to space type 0 |
| sp1_sel | output | 1 | Translated access to space type 1 |
| pa_word | output | 26 | Physical word address |
| rom_sel | output | 1 | Boot ROM fetch |
| rom_addr | output | 17 | Boot ROM word address |
| fault | output | 1 | Translated access faulted |
| fault_kind | output | 2 | 0 none, 1 invalid, 2 privilege, 3 write protect |

## Verification
The hardest state to reach is a page entry whose accessed bit was set by the translator itself, since that bit only changes as a side effect of a successful translation and the page map write path clears the neighbouring bits. The stimulus first builds a segment entry in a non-zero context, writes a page entry with garbage in bits 23:16, performs a translated access and then reads the entry back through the page map ASI to see bit 25 set and bits 23:16 clear. Context isolation is reached the same way: after switching the context register, the same virtual address lands on an untouched group and faults as invalid.

// File: rtl/mmu_pkg.sv
// Shared constants and types for the context translator.
// Assumes big-endian byte lanes: be[3] covers data bits 31:24.
package mmu_pkg;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_INVALID = 2'd1,
        FLT_PRIV    = 2'd2,
        FLT_WPROT   = 2'd3
    } fault_e;

    localparam logic [7:0] ASI_SYS  = 8'd2;
    localparam logic [7:0] ASI_SEG  = 8'd3;
    localparam logic [7:0] ASI_PAGE = 8'd4;
    localparam logic [7:0] ASI_SUP_INSN = 8'd9;

    localparam logic [3:0] SYS_SEL_CTX = 4'd3;
    localparam logic [3:0] SYS_SEL_EN  = 4'd4;

    localparam int PTE_VALID = 31;
    localparam int PTE_WRITE = 30;
    localparam int PTE_SUPER = 29;
    localparam int PTE_TYPE  = 26;
    localparam int PTE_ACC   = 25;
    localparam int PFN_BITS  = 16;
    localparam int WOFS_BITS = 10;

    localparam int SYSEN_RUN = 7;

endpackage

// File: rtl/mmu_sys_regs.sv
// Context and system enable registers.
// Assumes the top decodes the write strobes; only the upper byte lane writes.
module mmu_sys_regs #(
    parameter int CTX_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctx_we,
    input  logic                en_we,
    input  logic [7:0]          wbyte,
    output logic [CTX_BITS-1:0] ctx_q,
    output logic [7:0]          sysen_q
);

    // Hold the current context and enable byte; reset both to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_q   <= '0;
            sysen_q <= '0;
        end else begin
            if (ctx_we) ctx_q   <= wbyte[CTX_BITS-1:0];
            if (en_we)  sysen_q <= wbyte;
        end
    end

    logic unused_hi;
    assign unused_hi = ^wbyte[7:CTX_BITS];

endmodule

// File: rtl/mmu_seg_map.sv
// Per-context segment table: one group number per (context, segment).
// Assumes the stored depth SEG_IDX_BITS is a parameter; the index uses the
// low bits of the segment field. Read is asynchronous, write at the edge.
module mmu_seg_map #(
    parameter int CTX_BITS     = 3,
    parameter int SEG_IDX_BITS = 4,
    parameter int GRP_BITS     = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CTX_BITS-1:0]     ctx,
    input  logic [SEG_IDX_BITS-1:0] seg_idx,
    input  logic                    we,
    input  logic [7:0]              wbyte,
    output logic [GRP_BITS-1:0]     grp
);

    localparam int DEPTH = (1 << CTX_BITS) * (1 << SEG_IDX_BITS);
    localparam int AW    = CTX_BITS + SEG_IDX_BITS;

    logic [GRP_BITS-1:0] mem [DEPTH];
    logic [AW-1:0]       addr;

    assign addr = {ctx, seg_idx};
    assign grp  = mem[addr];

    // Clear on reset, otherwise store the masked group number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wbyte[GRP_BITS-1:0];
        end
    end

    generate
        if (GRP_BITS < 8) begin : g_unused
            logic unused_bits;
            assign unused_bits = ^wbyte[7:GRP_BITS];
        end
    endgenerate

endmodule

// File: rtl/mmu_page_map.sv
// Shared page table with byte-merged writes and an accessed-bit update.
// Assumes a write and an accessed update never target the same cycle
// (the top issues at most one request per cycle).
module mmu_page_map #(
    parameter int PG_IDX_BITS = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [PG_IDX_BITS-1:0] idx,
    input  logic                   we,
    input  logic [3:0]             be,
    input  logic [31:0]            wdata,
    input  logic                   set_acc,
    output logic [31:0]            pte
);
    import mmu_pkg::*;

    localparam int DEPTH = 1 << PG_IDX_BITS;

    logic [31:0] mem [DEPTH];
    logic [31:0] merged;

    assign pte = mem[idx];

    // Merge enabled bytes over the old entry, then clear bits 23:16.
    always_comb begin
        for (int b = 0; b < 4; b++)
            merged[8*b +: 8] = be[b] ? wdata[8*b +: 8] : pte[8*b +: 8];
        merged[23:16] = 8'h00;
    end

    // Clear on reset; commit writes or mark the entry as accessed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[idx] <= merged;
        end else if (set_acc) begin
            mem[idx][PTE_ACC] <= 1'b1;
        end
    end

endmodule

// File: rtl/ctx_mmu_xlate.sv
// Context-based two-level address translator.
// Decodes the ASI of each request, serves register and table accesses,
// translates ASI 8..11 through segment map then page map, and routes
// boot-mode supervisor fetches to ROM. Responses are combinational;
// state changes land on the next rising edge. Assumes GRP_IDX_BITS is
// not larger than GRP_BITS.
module ctx_mmu_xlate #(
    parameter int CTX_BITS     = 3,
    parameter int GRP_BITS     = 7,
    parameter int SEG_IDX_BITS = 4,
    parameter int GRP_IDX_BITS = 2,
    parameter int ROM_AW       = 17
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [7:0]  req_asi,
    input  logic        req_write,
    input  logic [31:0] req_addr,
    input  logic [3:0]  req_be,
    input  logic [31:0] req_wdata,
    input  logic [31:0] ext_rdata,
    input  logic [31:0] rom_rdata,
    output logic [31:0] rd_data,
    output logic        sp0_sel,
    output logic        sp1_sel,
    output logic [25:0] pa_word,
    output logic        rom_sel,
    output logic [16:0] rom_addr,
    output logic        fault,
    output logic [1:0]  fault_kind
);
    import mmu_pkg::*;

    localparam int PG_IDX_BITS = GRP_IDX_BITS + 6;

    logic                    is_sys, is_seg, is_page, is_xl;
    logic                    boot_mode, boot_hit, xl_act;
    logic [3:0]              sys_sel;
    logic [CTX_BITS-1:0]     ctx_q;
    logic [7:0]              sysen_q;
    logic [GRP_BITS-1:0]     grp;
    logic [PG_IDX_BITS-1:0]  pg_idx;
    logic [31:0]             pte;
    logic                    seg_hw, seg_byte, seg_we;
    logic [7:0]              seg_wbyte;
    logic                    ctx_we, en_we, pg_we;
    logic                    user_acc, xl_ok;
    logic [1:0]              sp_type;
    fault_e                  flt;

    // ASI decode
    assign is_sys  = req_valid && (req_asi == ASI_SYS);
    assign is_seg  = req_valid && (req_asi == ASI_SEG);
    assign is_page = req_valid && (req_asi == ASI_PAGE);
    assign is_xl   = req_valid && (req_asi[7:2] == 6'd2);
    assign sys_sel = req_addr[31:28];

    assign boot_mode = !sysen_q[SYSEN_RUN];
    assign boot_hit  = req_valid && (req_asi == ASI_SUP_INSN) && boot_mode;
    assign xl_act    = is_xl && !boot_hit;
    assign user_acc  = !req_asi[0];

    // Register write strobes
    assign ctx_we = is_sys && req_write && req_be[3] && (sys_sel == SYS_SEL_CTX);
    assign en_we  = is_sys && req_write && req_be[3] && (sys_sel == SYS_SEL_EN);

    // Segment map lane select: upper halfword or upper byte only
    assign seg_hw    = (req_be == 4'b1100);
    assign seg_byte  = (req_be == 4'b1000);
    assign seg_we    = is_seg && req_write && (seg_hw || seg_byte);
    assign seg_wbyte = seg_hw ? req_wdata[23:16] : req_wdata[31:24];

    assign pg_we  = is_page && req_write;
    assign pg_idx = {grp[GRP_IDX_BITS-1:0], req_addr[17:12]};

    mmu_sys_regs #(.CTX_BITS(CTX_BITS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctx_we  (ctx_we),
        .en_we   (en_we),
        .wbyte   (req_wdata[31:24]),
        .ctx_q   (ctx_q),
        .sysen_q (sysen_q)
    );

    mmu_seg_map #(
        .CTX_BITS     (CTX_BITS),
        .SEG_IDX_BITS (SEG_IDX_BITS),
        .GRP_BITS     (GRP_BITS)
    ) u_seg (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctx     (ctx_q),
        .seg_idx (req_addr[18 +: SEG_IDX_BITS]),
        .we      (seg_we),
        .wbyte   (seg_wbyte),
        .grp     (grp)
    );

    mmu_page_map #(.PG_IDX_BITS(PG_IDX_BITS)) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .idx     (pg_idx),
        .we      (pg_we),
        .be      (req_be),
        .wdata   (req_wdata),
        .set_acc (xl_ok),
        .pte     (pte)
    );

    // Fault classification in priority order: invalid, privilege, write.
    always_comb begin
        flt = FLT_NONE;
        if (xl_act) begin
            if (!pte[PTE_VALID])                         flt = FLT_INVALID;
            else if (user_acc && pte[PTE_SUPER])         flt = FLT_PRIV;
            else if (req_write && !pte[PTE_WRITE])       flt = FLT_WPROT;
        end
    end

    assign xl_ok      = xl_act && (flt == FLT_NONE);
    assign sp_type    = pte[PTE_TYPE +: 2];
    assign sp0_sel    = xl_ok && (sp_type == 2'd0);
    assign sp1_sel    = xl_ok && (sp_type == 2'd1);
    assign pa_word    = {pte[PFN_BITS-1:0], req_addr[11:2]};
    assign fault      = (flt != FLT_NONE);
    assign fault_kind = flt;

    assign rom_sel  = boot_hit && !req_write;
    assign rom_addr = req_addr[2 +: ROM_AW];

    // Read response mux.
    always_comb begin
        rd_data = '0;
        if (!req_write) begin
            if (rom_sel) begin
                rd_data = rom_rdata;
            end else if (is_sys) begin
                if (sys_sel == SYS_SEL_CTX)
                    rd_data[31:24] = {{(8-CTX_BITS){1'b0}}, ctx_q};
                else if (sys_sel == SYS_SEL_EN)
                    rd_data[31:24] = sysen_q;
            end else if (is_seg) begin
                if (seg_hw)        rd_data[23:16] = {{(8-GRP_BITS){1'b0}}, grp};
                else if (seg_byte) rd_data[31:24] = {{(8-GRP_BITS){1'b0}}, grp};
            end else if (is_page) begin
                rd_data = pte;
            end else if (sp0_sel || sp1_sel) begin
                rd_data = ext_rdata;
            end
        end
    end

    logic unused_misc;
    assign unused_misc = ^{req_addr[27:18+SEG_IDX_BITS], req_addr[1:0],
                           grp, pte[28], pte[24:PFN_BITS]};

endmodule

// File: rtl/ctx_mmu_xlate_chk.sv
// Property checker for ctx_mmu_xlate, attached with bind below.
module ctx_mmu_xlate_chk #(
    parameter int CTX_BITS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic [7:0]          req_asi,
    input logic                req_write,
    input logic [31:0]         req_addr,
    input logic [31:0]         rd_data,
    input logic                sp0_sel,
    input logic                sp1_sel,
    input logic [25:0]         pa_word,
    input logic                rom_sel,
    input logic                fault,
    input logic [CTX_BITS-1:0] ctx
);

    AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sp0_sel, sp1_sel, rom_sel})); // R5

    AST_PA_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (sp0_sel || sp1_sel) |-> (pa_word[9:0] == req_addr[11:2])); // R5

    AST_FAULT_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!sp0_sel && !sp1_sel)); // R7

    AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (rd_data == 32'h0)); // R7

    AST_FAULT_ONLY_XLATE: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (req_valid && (req_asi[7:2] == 6'd2))); // R7

    AST_ROM_SUP_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        rom_sel |-> (req_valid && req_asi == 8'd9 && !req_write)); // R10

    AST_CTX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write && req_asi == 8'd2 && req_addr[31:28] == 4'd3)
        |=> $stable(ctx)); // R2

endmodule

bind ctx_mmu_xlate ctx_mmu_xlate_chk #(.CTX_BITS(CTX_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_asi   (req_asi),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rd_data   (rd_data),
    .sp0_sel   (sp0_sel),
    .sp1_sel   (sp1_sel),
    .pa_word   (pa_word),
    .rom_sel   (rom_sel),
    .fault     (fault),
    .ctx       (ctx_q)
);

// File: tb/ctx_mmu_xlate_test.sv
module ctx_mmu_xlate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [7:0]  req_asi = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] ext_rdata, rom_rdata, rd_data;
    logic        sp0_sel, sp1_sel, rom_sel, fault;
    logic [25:0] pa_word;
    logic [16:0] rom_addr;
    logic [1:0]  fault_kind;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk; // 250 MHz

    // Downstream models derived from the addresses the block drives.
    assign ext_rdata = {6'b101010, pa_word};
    assign rom_rdata = {15'h1234, rom_addr};

    ctx_mmu_xlate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_asi(req_asi),
        .req_write(req_write), .req_addr(req_addr), .req_be(req_be),
        .req_wdata(req_wdata), .ext_rdata(ext_rdata), .rom_rdata(rom_rdata),
        .rd_data(rd_data), .sp0_sel(sp0_sel), .sp1_sel(sp1_sel),
        .pa_word(pa_word), .rom_sel(rom_sel), .rom_addr(rom_addr),
        .fault(fault), .fault_kind(fault_kind)
    );

    // Vector: asi, wr, addr, be, wdata, exp_rd, exp_fault, exp_sel, exp_pa, req#
    // exp_sel: 0 none, 1 sp0, 2 sp1, 3 rom
    localparam int VW = 147;
    localparam int NV = 30;
    localparam logic [VW-1:0] VEC [NV] = '{
        {8'd2, 1'b0, 32'h3000_0000, 4'hF, 32'h0, 32'h0000_0000, 2'd0, 2'd0, 26'h0, 8'd1},   // R1 ctx zero
        {8'd9, 1'b0, 32'h0000_1234, 4'hF, 32'h0, 32'h2468_048D, 2'd0, 2'd3, 26'h0, 8'd10},  // R10 boot ROM
        {8'd2, 1'b1, 32'h4000_0000, 4'hF, 32'h8000_0000, 32'h0, 2'd0, 2'd0, 26'h0, 8'd2},   // R2 leave boot
        {8'd2, 1'b0, 32'h4000_0000, 4'hF, 32'h0, 32'h8000_0000, 2'd0, 2'd0, 26'h0, 8'd2},   // R2 read enable
        {8'd2, 1'b1, 32'h3000_0000, 4'hF, 32'h0200_0000, 32'h0, 2'd0, 2'd0, 26'h0, 8'd2},   // R2 ctx=2
        {8'd2, 1'b0, 32'h3000_0000, 4'hF, 32'h0, 32'h0200_0000, 2'd0, 2'd0, 26'h0, 8'd2},   // R2
        {8'd3, 1'b1, 32'h0004_0000, 4'h8, 32'h8100_0000, 32'h0, 2'd0, 2'd0, 26'h0, 8'd3},   // R3 byte lane, mask
        {8'd3, 1'b0, 32'h0004_0000, 4'hC, 32'h0, 32'h0001_0000, 2'd0, 2'd0, 26'h0, 8'd3},   // R3 halfword read
        {8'd4, 1'b1, 32'h0004_3000, 4'hF, 32'h84FF_0123, 32'h0, 2'd0, 2'd0, 26'h0, 8'd4},   // R4 write
        {8'd4, 1'b0, 32'h0004_3000, 4'hF, 32'h0, 32'h8400_0123, 2'd0, 2'd0, 26'h0, 8'd4},   // R4 23:16 cleared
        {8'd10,1'b0, 32'h0004_3ABC, 4'hF, 32'h0, 32'hA804_8EAF, 2'd0, 2'd2, 26'h48EAF, 8'd5}, // R5 type1
        {8'd4, 1'b0, 32'h0004_3000, 4'hF, 32'h0, 32'h8600_0123, 2'd0, 2'd0, 26'h0, 8'd6},   // R6 accessed set
        {8'd11,1'b1, 32'h0004_3000, 4'hF, 32'h1111_1111, 32'h0, 2'd3, 2'd0, 26'h0, 8'd9},  // R9 write protect
        {8'd4, 1'b1, 32'h0004_4000, 4'hF, 32'hE000_0077, 32'h0, 2'd0, 2'd0, 26'h0, 8'd4},   // R4 second entry
        {8'd8, 1'b0, 32'h0004_4010, 4'hF, 32'h0, 32'h0, 2'd2, 2'd0, 26'h0, 8'd8},           // R8 user to super
        {8'd11,1'b1, 32'h0004_4010, 4'hF, 32'h5555_AAAA, 32'h0, 2'd0, 2'd1, 26'h1DC04, 8'd5}, // R5 type0 write
        {8'd4, 1'b0, 32'h0004_4000, 4'hF, 32'h0, 32'hE200_0077, 2'd0, 2'd0, 26'h0, 8'd6},   // R6
        {8'd10,1'b0, 32'h0004_5000, 4'hF, 32'h0, 32'h0, 2'd1, 2'd0, 26'h0, 8'd7},           // R7 invalid
        {8'd9, 1'b0, 32'h0004_3000, 4'hF, 32'h0, 32'hA804_8C00, 2'd0, 2'd2, 26'h48C00, 8'd10}, // R10 translated
        {8'd2, 1'b1, 32'h3000_0000, 4'h8, 32'h0000_0000, 32'h0, 2'd0, 2'd0, 26'h0, 8'd11},  // R11 ctx=0
        {8'd10,1'b0, 32'h0004_3000, 4'hF, 32'h0, 32'h0, 2'd1, 2'd0, 26'h0, 8'd11},          // R11 other ctx
        {8'd4, 1'b1, 32'h0000_2000, 4'h9, 32'h9CAB_CD55, 32'h0, 2'd0, 2'd0, 26'h0, 8'd4},   // R4 byte merge
        {8'd4, 1'b0, 32'h0000_2000, 4'hF, 32'h0, 32'h9C00_0055, 2'd0, 2'd0, 26'h0, 8'd4},   // R4
        {8'd10,1'b0, 32'h0000_2000, 4'hF, 32'h0, 32'h0, 2'd0, 2'd0, 26'h0, 8'd5},           // R5 type3 none
        {8'd4, 1'b0, 32'h0000_2000, 4'hF, 32'h0, 32'h9E00_0055, 2'd0, 2'd0, 26'h0, 8'd6},   // R6
        {8'd3, 1'b0, 32'h0004_0000, 4'hF, 32'h0, 32'h0, 2'd0, 2'd0, 26'h0, 8'd3},           // R3 bad lanes
        {8'd2, 1'b1, 32'h3000_0000, 4'hF, 32'hFF00_0000, 32'h0, 2'd0, 2'd0, 26'h0, 8'd2},   // R2 ctx truncation
        {8'd2, 1'b0, 32'h3000_0000, 4'hF, 32'h0, 32'h0700_0000, 2'd0, 2'd0, 26'h0, 8'd2},   // R2
        {8'd3, 1'b1, 32'h0008_0000, 4'hC, 32'h00AB_0000, 32'h0, 2'd0, 2'd0, 26'h0, 8'd3},   // R3 halfword write
        {8'd3, 1'b0, 32'h0008_0000, 4'h8, 32'h0, 32'h2B00_0000, 2'd0, 2'd0, 26'h0, 8'd3}    // R3 byte read
    };

    task automatic check(input bit ok, input string what, input int req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one request on the falling edge, compare before the rising edge.
    task automatic run_op(input logic [7:0] asi, input logic wr, input logic [31:0] addr,
                          input logic [3:0] be, input logic [31:0] wd,
                          input logic [31:0] e_rd, input logic [1:0] e_flt,
                          input logic [1:0] e_sel, input logic [25:0] e_pa, input int req);
        logic [1:0] sel;
        @(negedge clk);
        req_valid = 1'b1; req_asi = asi; req_write = wr;
        req_addr = addr; req_be = be; req_wdata = wd;
        #1;
        sel = rom_sel ? 2'd3 : sp1_sel ? 2'd2 : sp0_sel ? 2'd1 : 2'd0;
        check(rd_data == e_rd, "rd_data", req, rd_data, e_rd);
        check(fault_kind == e_flt && fault == (e_flt != 2'd0), "fault", req,
              {29'b0, fault, fault_kind}, {29'b0, e_flt != 2'd0, e_flt});
        check(sel == e_sel, "select", req, {30'b0, sel}, {30'b0, e_sel});
        if (e_sel == 2'd1 || e_sel == 2'd2)
            check(pa_word == e_pa, "pa_word", req, {6'b0, pa_word}, {6'b0, e_pa});
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: after reset the enable register reads zero and no select is active when idle
        run_op(8'd2, 1'b0, 32'h4000_0000, 4'hF, 32'h0, 32'h0, 2'd0, 2'd0, 26'h0, 1); // R1
        idle();
        #1;
        check(!sp0_sel && !sp1_sel && !rom_sel && !fault, "idle outputs", 1,
              {28'b0, sp0_sel, sp1_sel, rom_sel, fault}, 32'h0); // R1

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            run_op(v[146:139], v[138], v[137:106], v[105:102], v[101:70],
                   v[69:38], v[37:36], v[35:34], v[33:8], int'(v[7:0]));
        end

        // R2: other system-space registers read zero
        run_op(8'd2, 1'b0, 32'h5000_0000, 4'hF, 32'h0, 32'h0, 2'd0, 2'd0, 26'h0, 2); // R2

        // R10: a boot-mode supervisor write is not sent to ROM
        // (after reset below)

        // R1: reset in mid-run restores boot mode and context zero
        @(negedge clk) rst_n = 1'b0; req_valid = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        run_op(8'd2, 1'b0, 32'h3000_0000, 4'hF, 32'h0, 32'h0, 2'd0, 2'd0, 26'h0, 1);   // R1 ctx
        run_op(8'd2, 1'b0, 32'h4000_0000, 4'hF, 32'h0, 32'h0, 2'd0, 2'd0, 26'h0, 1);   // R1 enable
        run_op(8'd9, 1'b0, 32'h0007_FFFC, 4'hF, 32'h0, 32'h2469_FFFF, 2'd0, 2'd3, 26'h0, 1); // R1 ROM top
        run_op(8'd4, 1'b0, 32'h0004_3000, 4'hF, 32'h0, 32'h0, 2'd0, 2'd0, 26'h0, 1);   // R1 table cleared
        run_op(8'd9, 1'b1, 32'h0000_0040, 4'hF, 32'h0, 32'h0, 2'd0, 2'd0, 26'h0, 10);  // R10 write no ROM
        idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        done = 1;
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule